// File: doc/BRIEF.md
# Time-Slot Scheduled Two-Class Router

This block is a single switching node for an on-chip network with a fixed set of full-duplex ports. Every link is one flit wide. Each input flit carries a class bit. Guaranteed flits are switched without contention. A programmable schedule decides where each one goes. The schedule holds one entry per time slot. A global slot counter selects the entry, and it advances in lockstep with every other node. Because the schedule already keeps guaranteed flits apart, they pass through no arbitration and never wait. A single one-flit register per input is enough to hold them.

Best-effort flits share the same links. They fill only the outputs that the schedule leaves unused in the current slot. An output is also unused when its entry is enabled but the chosen input holds no guaranteed flit. Each input queues best-effort flits in a small FIFO and signals when that FIFO is full. Each output picks among the waiting heads in round-robin order. A configuration port writes schedule entries. The schedule itself is computed elsewhere.

Top module: `rtr_router`

## Requirements
- R1: While reset is held, every output valid bit is 0, every error bit is 0, every full bit is 0 and the slot index is 0.
- R2: The slot index increases by one on every clock edge and returns to 0 after the value SLOTS-1.
- R3: A guaranteed flit (class bit 1) is presented on input i while the slot index is s. For every output o whose entry for slot (s+1) mod SLOTS is enabled with source i, that flit appears on o with class 1 two edges later. One flit may therefore reach several outputs.
- R4: If no enabled output in entry (s+1) mod SLOTS selects input i, that guaranteed flit is discarded. Error bit i is then 1 for exactly the cycle in which the flit would have appeared.
- R5: A best-effort flit (class bit 0) names its destination output in its lowest log2(PORTS) bits. If that output is free and uncontested, the flit appears there with class 1 cleared two edges after it was presented.
- R6: An output that carries a guaranteed flit in a cycle grants nothing to best-effort traffic in that cycle. The waiting best-effort flit leaves on the first later cycle in which the output is free.
- R7: An output whose entry is enabled, but whose chosen input holds no guaranteed flit, is free for best-effort traffic.
- R8: Each output grants contending best-effort heads in round-robin order. After reset it searches from input 0. After a grant to input g, the next search starts at input g+1, wrapping modulo PORTS.
- R9: Each best-effort FIFO holds BE_DEPTH flits in arrival order. Its full bit is 1 while it holds BE_DEPTH flits. A best-effort flit presented while the full bit is 1 is discarded.
- R10: A schedule write replaces the enable mask and the per-output source fields of the addressed slot entry. The source of output o sits in bits [2o+1:2o] of the source field. Every slot evaluated after the write edge uses the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | PORTS | Flit present on each input |
| inClass | input | PORTS | 1 = guaranteed, 0 = best-effort |
| inData | input | PORTS*FLIT_W | Input flits, port i at bits [i*FLIT_W +: FLIT_W] |
| beFull | output | PORTS | Best-effort FIFO of each input is full |
| tblWrEn | input | 1 | Write one schedule entry |
| tblWrSlot | input | SLOT_W | Slot addressed by the write |
| tblWrMask | input | PORTS | Enable bit for each output |
| tblWrSel | input | PORTS*IDX_W | Source input for each output |
| slotNow | output | SLOT_W | Current slot index |
| outValid | output | PORTS | Flit present on each output |
| outClass | output | PORTS | Class of each output flit |
| outData | output | PORTS*FLIT_W | Output flits |
| gtErr | output | PORTS | Unroutable guaranteed flit dropped on that input |

## Verification
Both classes pass two registers: the input buffer or FIFO, then the output register. An uncontested flit presented in the cycle at slot s is therefore visible after the second rising edge. The bench drives inputs on a falling edge and clears them one falling edge later. It samples outputs and error bits on the next falling edge, where the schedule entry for slot s+1 applies. A flit that was held back by a guaranteed claim or by round-robin contention is expected one falling edge later for each cycle it waited. The full bit is checked one falling edge after the push that fills the FIFO.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  // Port count of the router; kept a power of two so source indices wrap.
  localparam int RTR_PORTS = 4;
  localparam int IDX_W     = $clog2(RTR_PORTS);

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic [RTR_PORTS-1:0]            gtOut;   // output loads a guaranteed flit
    logic [RTR_PORTS-1:0]            beOut;   // output loads a best-effort flit
    logic [RTR_PORTS-1:0][IDX_W-1:0] srcSel;  // source input per output
    logic [RTR_PORTS-1:0]            bePop;   // FIFO pop per input
  } xbarStrobe_t;
endpackage

// File: rtl/rtr_be_fifo.sv
module rtr_be_fifo #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [FLIT_W-1:0] wrData,
  output logic [FLIT_W-1:0] rdData,
  output logic              notEmpty,
  output logic              full
);
  logic [DEPTH-1:0][FLIT_W-1:0] mem;
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic doPush, doPop;

  assign full     = (count == (AW+1)'(DEPTH));
  assign notEmpty = (count != '0);
  assign doPush   = push && !full;
  assign doPop    = pop && notEmpty;
  assign rdData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rtr_ctrl.sv
module rtr_ctrl
  import rtr_pkg::*;
#(
  parameter int SLOTS   = 8,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tblWrEn,
  input  logic [SLOT_W-1:0]                tblWrSlot,
  input  logic [RTR_PORTS-1:0]             tblWrMask,
  input  logic [RTR_PORTS-1:0][IDX_W-1:0]  tblWrSel,
  input  logic [RTR_PORTS-1:0]             gtHeld,
  input  logic [RTR_PORTS-1:0]             beHeadValid,
  input  logic [RTR_PORTS-1:0][IDX_W-1:0]  beHeadDest,
  output logic [SLOT_W-1:0]                slotNow,
  output logic [RTR_PORTS-1:0]             gtErr,
  output xbarStrobe_t                      strobe
);
  // Schedule storage: enable mask and source field per slot.
  logic [SLOTS-1:0][RTR_PORTS-1:0]            entValid;
  logic [SLOTS-1:0][RTR_PORTS-1:0][IDX_W-1:0] entSel;

  logic [RTR_PORTS-1:0]            curValid, claimed, routed, grantValid;
  logic [RTR_PORTS-1:0][IDX_W-1:0] curSel, grantIdx, rrPtr;

  // Slot counter, common time base with all nodes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               slotNow <= '0;
    else if (slotNow == SLOT_W'(SLOTS - 1))  slotNow <= '0;
    else                                     slotNow <= slotNow + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entSel   <= '0;
    end else if (tblWrEn) begin
      entValid[tblWrSlot] <= tblWrMask;
      entSel[tblWrSlot]   <= tblWrSel;
    end
  end

  assign curValid = entValid[slotNow];
  assign curSel   = entSel[slotNow];

  // Guaranteed claims and routing coverage of each input.
  always_comb begin
    routed = '0;
    for (int o = 0; o < RTR_PORTS; o++) begin
      claimed[o] = curValid[o] && gtHeld[curSel[o]];
      for (int i = 0; i < RTR_PORTS; i++) begin
        if (curValid[o] && curSel[o] == IDX_W'(i)) routed[i] = 1'b1;
      end
    end
  end

  // Round-robin search per output over best-effort heads.
  always_comb begin
    for (int o = 0; o < RTR_PORTS; o++) begin
      grantValid[o] = 1'b0;
      grantIdx[o]   = '0;
      for (int k = 0; k < RTR_PORTS; k++) begin
        logic [IDX_W-1:0] cand;
        cand = rrPtr[o] + IDX_W'(k);
        if (!grantValid[o] && beHeadValid[cand] && beHeadDest[cand] == IDX_W'(o)) begin
          grantValid[o] = 1'b1;
          grantIdx[o]   = cand;
        end
      end
    end
  end

  always_comb begin
    strobe.gtOut = claimed;
    strobe.bePop = '0;
    for (int o = 0; o < RTR_PORTS; o++) begin
      strobe.beOut[o]  = !claimed[o] && grantValid[o];
      strobe.srcSel[o] = claimed[o] ? curSel[o] : grantIdx[o];
    end
    for (int i = 0; i < RTR_PORTS; i++) begin
      for (int o = 0; o < RTR_PORTS; o++) begin
        if (strobe.beOut[o] && grantIdx[o] == IDX_W'(i)) strobe.bePop[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
      gtErr <= '0;
    end else begin
      gtErr <= gtHeld & ~routed;
      for (int o = 0; o < RTR_PORTS; o++) begin
        if (strobe.beOut[o]) rrPtr[o] <= grantIdx[o] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtr_datapath.sv
module rtr_datapath
  import rtr_pkg::*;
#(
  parameter int FLIT_W   = 16,
  parameter int BE_DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [RTR_PORTS-1:0]             inValid,
  input  logic [RTR_PORTS-1:0]             inClass,
  input  logic [RTR_PORTS*FLIT_W-1:0]      inData,
  input  xbarStrobe_t                      strobe,
  output logic [RTR_PORTS-1:0]             gtHeld,
  output logic [RTR_PORTS-1:0]             beHeadValid,
  output logic [RTR_PORTS-1:0][IDX_W-1:0]  beHeadDest,
  output logic [RTR_PORTS-1:0]             beFull,
  output logic [RTR_PORTS-1:0]             outValid,
  output logic [RTR_PORTS-1:0]             outClass,
  output logic [RTR_PORTS*FLIT_W-1:0]      outData
);
  logic [RTR_PORTS-1:0][FLIT_W-1:0] gtData, beHead, outFlit;

  // One-flit guaranteed register per input: refilled every cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gtHeld <= '0;
      gtData <= '0;
    end else begin
      for (int i = 0; i < RTR_PORTS; i++) begin
        gtHeld[i] <= inValid[i] && inClass[i];
        gtData[i] <= inData[i*FLIT_W +: FLIT_W];
      end
    end
  end

  for (genvar i = 0; i < RTR_PORTS; i++) begin : g_beq
    rtr_be_fifo #(.FLIT_W(FLIT_W), .DEPTH(BE_DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (inValid[i] && !inClass[i]),
      .pop      (strobe.bePop[i]),
      .wrData   (inData[i*FLIT_W +: FLIT_W]),
      .rdData   (beHead[i]),
      .notEmpty (beHeadValid[i]),
      .full     (beFull[i])
    );
    assign beHeadDest[i] = beHead[i][IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      outClass <= '0;
      outFlit  <= '0;
    end else begin
      for (int o = 0; o < RTR_PORTS; o++) begin
        outValid[o] <= strobe.gtOut[o] || strobe.beOut[o];
        outClass[o] <= strobe.gtOut[o];
        if (strobe.gtOut[o])      outFlit[o] <= gtData[strobe.srcSel[o]];
        else if (strobe.beOut[o]) outFlit[o] <= beHead[strobe.srcSel[o]];
      end
    end
  end

  assign outData = outFlit;
endmodule

// File: rtl/rtr_router.sv
module rtr_router
  import rtr_pkg::*;
#(
  parameter int FLIT_W   = 16,
  parameter int SLOTS    = 8,
  parameter int BE_DEPTH = 4,
  localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [RTR_PORTS-1:0]        inValid,
  input  logic [RTR_PORTS-1:0]        inClass,
  input  logic [RTR_PORTS*FLIT_W-1:0] inData,
  output logic [RTR_PORTS-1:0]        beFull,
  input  logic                        tblWrEn,
  input  logic [SLOT_W-1:0]           tblWrSlot,
  input  logic [RTR_PORTS-1:0]        tblWrMask,
  input  logic [RTR_PORTS*IDX_W-1:0]  tblWrSel,
  output logic [SLOT_W-1:0]           slotNow,
  output logic [RTR_PORTS-1:0]        outValid,
  output logic [RTR_PORTS-1:0]        outClass,
  output logic [RTR_PORTS*FLIT_W-1:0] outData,
  output logic [RTR_PORTS-1:0]        gtErr
);
  xbarStrobe_t                     strobe;
  logic [RTR_PORTS-1:0]            gtHeld, beHeadValid;
  logic [RTR_PORTS-1:0][IDX_W-1:0] beHeadDest;

  rtr_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tblWrEn     (tblWrEn),
    .tblWrSlot   (tblWrSlot),
    .tblWrMask   (tblWrMask),
    .tblWrSel    (tblWrSel),
    .gtHeld      (gtHeld),
    .beHeadValid (beHeadValid),
    .beHeadDest  (beHeadDest),
    .slotNow     (slotNow),
    .gtErr       (gtErr),
    .strobe      (strobe)
  );

  rtr_datapath #(.FLIT_W(FLIT_W), .BE_DEPTH(BE_DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inClass     (inClass),
    .inData      (inData),
    .strobe      (strobe),
    .gtHeld      (gtHeld),
    .beHeadValid (beHeadValid),
    .beHeadDest  (beHeadDest),
    .beFull      (beFull),
    .outValid    (outValid),
    .outClass    (outClass),
    .outData     (outData)
  );
endmodule

// File: rtl/rtr_router_chk.sv
module rtr_router_chk
  import rtr_pkg::*;
#(
  parameter int SLOTS   = 8,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [RTR_PORTS-1:0] inValid,
  input logic [RTR_PORTS-1:0] inClass,
  input logic [SLOT_W-1:0]    slotNow,
  input logic [RTR_PORTS-1:0] outValid,
  input logic [RTR_PORTS-1:0] outClass,
  input logic [RTR_PORTS-1:0] gtErr,
  input logic [RTR_PORTS-1:0] beFull
);
  // Edges seen since reset release, saturating.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (outValid == '0 && gtErr == '0 && beFull == '0 && slotNow == '0));

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotNow == SLOT_W'(SLOTS - 1) |=> slotNow == '0);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotNow != SLOT_W'(SLOTS - 1) |=> slotNow == $past(slotNow) + 1'b1);

  for (genvar p = 0; p < RTR_PORTS; p++) begin : g_port
    // R4
    err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      (age >= 2'd2 && gtErr[p]) |-> $past(inValid[p] && inClass[p], 2));

    // R3
    gt_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      (age >= 2'd2 && outValid[p] && outClass[p]) |-> $past(|(inValid & inClass), 2));

    // R9
    full_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(beFull[p]) |-> $past(inValid[p] && !inClass[p]));
  end
endmodule

bind rtr_router rtr_router_chk #(.SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inClass  (inClass),
  .slotNow  (slotNow),
  .outValid (outValid),
  .outClass (outClass),
  .gtErr    (gtErr),
  .beFull   (beFull)
);

// File: tb/rtr_router_test.sv
module rtr_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 4;
  localparam int FW = 16;

  typedef struct packed {
    logic [2:0]  slot;
    logic [3:0]  vld;
    logic [3:0]  cls;
    logic [63:0] dat;
    logic [3:0]  eVld;
    logic [3:0]  eCls;
    logic [63:0] eDat;
    logic [3:0]  eErr;
    logic [7:0]  req;
  } vec_t;

  // Schedule used by the vectors: slot1 out1<-in0, out2<-in3;
  // slot2 out0<-in2; slot3 out0<-in1 and out3<-in1; all others disabled.
  localparam vec_t VECS [7] = '{
    // R3 two guaranteed flits to two outputs
    '{3'd0, 4'b1001, 4'b1001, 64'hB002_0000_0000_A001, 4'b0110, 4'b0110, 64'h0000_B002_A001_0000, 4'b0000, 8'd3},
    // R7 enabled output with idle source carries best-effort
    '{3'd0, 4'b0101, 4'b0001, 64'h0000_C002_0000_A010, 4'b0110, 4'b0010, 64'h0000_C002_A010_0000, 4'b0000, 8'd7},
    // R6 guaranteed claim wins output 0
    '{3'd1, 4'b0110, 4'b0100, 64'h0000_D0F0_1230_0000, 4'b0001, 4'b0001, 64'h0000_0000_0000_D0F0, 4'b0000, 8'd6},
    // R3 one flit to two outputs
    '{3'd2, 4'b0010, 4'b0010, 64'h0000_0000_7777_0000, 4'b1001, 4'b1001, 64'h7777_0000_0000_7777, 4'b0000, 8'd3},
    // R4 unroutable flit dropped
    '{3'd4, 4'b0100, 4'b0100, 64'h0000_EEEE_0000_0000, 4'b0000, 4'b0000, 64'h0, 4'b0100, 8'd4},
    // R5 two best-effort flits to distinct outputs
    '{3'd5, 4'b0011, 4'b0000, 64'h0000_0000_5551_4443, 4'b1010, 4'b0000, 64'h4443_0000_5551_0000, 4'b0000, 8'd5},
    // R4 two unroutable flits
    '{3'd6, 4'b1001, 4'b1001, 64'h9999_0000_0000_8888, 4'b0000, 4'b0000, 64'h0, 4'b1001, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [P-1:0]  inValid = '0, inClass = '0;
  logic [P*FW-1:0] inData = '0;
  logic          tblWrEn = 1'b0;
  logic [2:0]    tblWrSlot = '0;
  logic [P-1:0]  tblWrMask = '0;
  logic [7:0]    tblWrSel = '0;
  logic [P-1:0]  beFull, outValid, outClass, gtErr;
  logic [2:0]    slotNow;
  logic [P*FW-1:0] outData;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtr_router #(.FLIT_W(FW), .SLOTS(8), .BE_DEPTH(4)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .inData(inData),
    .beFull(beFull), .tblWrEn(tblWrEn), .tblWrSlot(tblWrSlot), .tblWrMask(tblWrMask),
    .tblWrSel(tblWrSel), .slotNow(slotNow), .outValid(outValid), .outClass(outClass),
    .outData(outData), .gtErr(gtErr)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    inValid = '0; inClass = '0; inData = '0;
  endtask

  task automatic writeEntry(input int s, input logic [3:0] mask, input logic [7:0] sel);
    tblWrEn = 1'b1; tblWrSlot = 3'(s); tblWrMask = mask; tblWrSel = sel;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  function automatic logic [15:0] lane(input logic [63:0] v, input int p);
    return v[p*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] got [8];
    int nGot;
    logic [2:0] prev;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(outValid == '0, "R1 outValid", 64'(outValid), 0);
    check(gtErr == '0 && beFull == '0, "R1 err/full", 64'({gtErr, beFull}), 0);
    check(slotNow == '0, "R1 slot", 64'(slotNow), 0);
    rstN = 1'b1;

    // R2 slot sequence and wrap
    @(negedge clk);
    for (int c = 0; c < 10; c++) begin
      prev = slotNow;
      @(negedge clk);
      check(slotNow == ((prev == 3'd7) ? 3'd0 : prev + 3'd1), "R2 slot step", 64'(slotNow), 64'(prev));
    end

    // R10 program the schedule used by the vectors
    writeEntry(1, 4'b0110, {2'd0, 2'd3, 2'd0, 2'd0});
    writeEntry(2, 4'b0001, {2'd0, 2'd0, 2'd0, 2'd2});
    writeEntry(3, 4'b1001, {2'd1, 2'd0, 2'd0, 2'd1});

    for (int v = 0; v < 7; v++) begin
      while (slotNow != VECS[v].slot) @(negedge clk);
      inValid = VECS[v].vld; inClass = VECS[v].cls; inData = VECS[v].dat;
      @(negedge clk);
      idle();
      @(negedge clk);
      for (int o = 0; o < P; o++) begin
        check(outValid[o] == VECS[v].eVld[o], $sformatf("R%0d vector %0d valid[%0d]", VECS[v].req, v, o),
              64'(outValid[o]), 64'(VECS[v].eVld[o]));
        if (VECS[v].eVld[o]) begin
          check(outClass[o] == VECS[v].eCls[o] && outData[o*16 +: 16] == lane(VECS[v].eDat, o),
                $sformatf("R%0d vector %0d flit[%0d]", VECS[v].req, v, o),
                64'({outClass[o], outData[o*16 +: 16]}), 64'({VECS[v].eCls[o], lane(VECS[v].eDat, o)}));
        end
      end
      check(gtErr == VECS[v].eErr, $sformatf("R%0d vector %0d error", VECS[v].req, v), 64'(gtErr), 64'(VECS[v].eErr));
      @(negedge clk);
      // R6 held best-effort flit leaves once output 0 is free
      if (v == 2) check(outValid[0] && !outClass[0] && outData[15:0] == 16'h1230, "R6 deferred flit",
                        64'({outValid[0], outClass[0], outData[15:0]}), 64'h2_1230);
      if (v == 4 || v == 6) check(outValid == '0 && gtErr == '0, "R4 dropped flit stays gone",
                                  64'({outValid, gtErr}), 0);
      repeat (2) @(negedge clk);
    end

    // R8 three heads contend for output 3; pointer of output 3 is at input 1
    while (slotNow != 3'd0) @(negedge clk);
    inValid = 4'b0111; inClass = '0;
    inData = {16'h0000, 16'h3003, 16'h2003, 16'h1003};
    @(negedge clk);
    idle();
    @(negedge clk);
    check(outValid[3] && outData[63:48] == 16'h2003, "R8 first grant", 64'(outData[63:48]), 64'h2003);
    @(negedge clk);
    check(outValid[3] && outData[63:48] == 16'h3003, "R8 second grant", 64'(outData[63:48]), 64'h3003);
    @(negedge clk);
    check(outValid[3] && outData[63:48] == 16'h1003, "R8 third grant", 64'(outData[63:48]), 64'h1003);
    repeat (3) @(negedge clk);

    // R10 rewrite every slot: output 0 from input 3
    for (int s = 0; s < 8; s++) writeEntry(s, 4'b0001, {2'd0, 2'd0, 2'd0, 2'd3});

    // R9 guaranteed stream on input 3 starves best-effort on input 1
    for (int k = 0; k < 10; k++) begin
      if (k == 4) check(outValid[0] && outClass[0] && outData[15:0] == 16'h6002, "R10 new entry used",
                        64'({outValid[0], outClass[0], outData[15:0]}), 64'h3_6002);
      if (k == 5) check(beFull[1] == 1'b0, "R9 not full at three", 64'(beFull[1]), 0);
      if (k == 6) check(beFull[1] == 1'b1, "R9 full at depth", 64'(beFull[1]), 1);
      idle();
      inValid[3] = 1'b1; inClass[3] = 1'b1; inData[63:48] = 16'h6000 + 16'(k);
      if (k >= 2 && k <= 5) begin
        inValid[1] = 1'b1; inData[31:16] = 16'h0100 + 16'(4 * (k - 2));
      end
      if (k == 7) begin
        inValid[1] = 1'b1; inData[31:16] = 16'h0110;
      end
      @(negedge clk);
    end
    idle();
    nGot = 0;
    for (int c = 0; c < 12; c++) begin
      if (outValid[0] && !outClass[0] && nGot < 8) begin
        got[nGot] = outData[15:0];
        nGot++;
      end
      @(negedge clk);
    end
    check(nGot == 4, "R9 drained count", 64'(nGot), 4);
    for (int n = 0; n < 4; n++) begin
      if (n < nGot) check(got[n] == 16'h0100 + 16'(4 * n), "R9 order", 64'(got[n]), 64'(16'h0100 + 16'(4 * n)));
    end
    check(beFull[1] == 1'b0, "R9 full clears", 64'(beFull[1]), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule